// File: doc/BRIEF.md
# Fetch Translation Miss Responder

This block answers an instruction-fetch address translation request that has already missed the first-level TLB. In the cycle the request is presented, the second-level TLB lookup result (hit flag and page data), a speculative flag and a pipeline-idle flag arrive with it. The block then chooses one of four answers. A hit returns the page. A speculative miss is aborted when speculative aborts are enabled. A non-speculative miss is told to retry while the pipeline is busy. It starts a page walk when the pipeline is idle.

When a walk is started, the block raises a walk request and holds it until the walk engine grants it. It then waits for the walk-done strobe and returns the walked page as a second response. While a walk is outstanding, the block drops its ready output and ignores new requests. The enable for speculative aborts is a level input. It is driven from a configuration bit that resets to disabled. While it is clear, the speculative flag has no effect.

Top module: `fetch_miss_resp`

## Requirements
- R1: A request accepted (req_valid high while ready high) with l2_hit high produces, on the next cycle, resp_valid high, resp_kind 2'b00 (page) and resp_page equal to the l2_page value presented with the request.
- R2: An accepted request with l2_hit low, req_spec high and spec_abort_en high produces resp_kind 2'b01 (abort) on the next cycle.
- R3: An accepted request with l2_hit low that is treated as non-speculative, with pipe_idle low, produces resp_kind 2'b10 (retry) on the next cycle.
- R4: An accepted request with l2_hit low that is treated as non-speculative, with pipe_idle high, produces resp_kind 2'b11 (walk started) on the next cycle. walk_req rises in that same cycle.
- R5: While spec_abort_en is low, req_spec has no effect: a speculative miss gets retry or walk exactly as a non-speculative one would.
- R6: During and right after reset, resp_valid and walk_req are low and ready is high.
- R7: resp_valid is a single-cycle pulse. An accepted request gives exactly one pulse, and a request presented while ready is low gives none.
- R8: walk_req stays high until a cycle with walk_gnt high, and is low in the cycle after that grant.
- R9: After the grant, a walk_done strobe produces, on the next cycle, resp_valid high with resp_kind 2'b00 and resp_page equal to walk_page.
- R10: ready is low from the cycle the walk-started response appears until the cycle the walked page response appears, and is high again from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spec_abort_en | input | 1 | Enables aborting speculative misses |
| req_valid | input | 1 | Translation request present with its lookup result |
| req_spec | input | 1 | Request is speculative |
| pipe_idle | input | 1 | Pipeline idle, sampled with the request |
| l2_hit | input | 1 | Second-level TLB hit |
| l2_page | input | PAGE_W | Page data from the second-level TLB |
| ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response strobe |
| resp_kind | output | 2 | 00 page, 01 abort, 10 retry, 11 walk started |
| resp_page | output | PAGE_W | Page carried with a page response |
| walk_req | output | 1 | Page walk request |
| walk_gnt | input | 1 | Walk engine accepts walk_req |
| walk_done | input | 1 | Walk finished, walk_page valid |
| walk_page | input | PAGE_W | Page found by the walk |

## Verification
A wrong decision shows at resp_kind in the cycle after the request, so the bench sweeps every combination of hit, speculative, idle and enable, and compares against the four-way rule. A walk controller stuck in the wrong state shows within one cycle as a ready level that disagrees with the walk handshake, as a walk_req that drops early or stays high, or as a missing or extra response pulse. The bench presents requests during a walk to expose a controller that stays ready while a walk is outstanding.

// File: rtl/fmr_pkg.sv
// Shared types for the fetch translation miss responder.
// Assumes: the response code values are decoded by the fetch unit.
package fmr_pkg;
    typedef enum logic [1:0] {
        RK_PAGE  = 2'b00,
        RK_ABORT = 2'b01,
        RK_RETRY = 2'b10,
        RK_WALK  = 2'b11
    } resp_kind_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'b00,
        WS_REQ  = 2'b01,
        WS_WAIT = 2'b10
    } walk_state_e;
endpackage

// File: rtl/fmr_classify.sv
// Picks the answer for a first-level miss from the second-level result.
// Assumes: all inputs belong to the same request cycle; purely combinational.
module fmr_classify
    import fmr_pkg::*;
(
    input  logic       l2_hit,
    input  logic       spec,
    input  logic       idle,
    input  logic       abort_en,
    output resp_kind_e kind
);
    logic eff_spec;

    // A speculative flag only counts when aborts are enabled.
    always_comb eff_spec = spec & abort_en;

    // Priority: hit, then speculative abort, then idle walk, else retry.
    always_comb begin
        if (l2_hit)        kind = RK_PAGE;
        else if (eff_spec) kind = RK_ABORT;
        else if (idle)     kind = RK_WALK;
        else               kind = RK_RETRY;
    end
endmodule

// File: rtl/fmr_walk_fsm.sv
// Tracks one outstanding page walk: request, grant, completion.
// Assumes: walk_done only follows a grant; one walk at a time.
module fmr_walk_fsm
    import fmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic walk_gnt,
    input  logic walk_done,
    output logic walk_req,
    output logic ready,
    output logic finish
);
    walk_state_e state, state_nx;

    // Next-state decision for the walk handshake.
    always_comb begin
        state_nx = state;
        case (state)
            WS_IDLE: if (start)     state_nx = WS_REQ;
            WS_REQ:  if (walk_gnt)  state_nx = WS_WAIT;
            WS_WAIT: if (walk_done) state_nx = WS_IDLE;
            default:                state_nx = WS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    // Outputs decoded from the current state.
    always_comb begin
        walk_req = (state == WS_REQ);
        ready    = (state == WS_IDLE);
        finish   = (state == WS_WAIT) && walk_done;
    end

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_gnt |=> walk_req);
    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_gnt |=> !walk_req);
    p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && walk_req));
endmodule

// File: rtl/fmr_resp_reg.sv
// Registers the single response pulse and its page payload.
// Assumes: load_req and load_walk never occur together.
module fmr_resp_reg
    import fmr_pkg::*;
#(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  resp_kind_e        req_kind,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              load_walk,
    input  logic [PAGE_W-1:0] walk_page,
    output logic              resp_valid,
    output resp_kind_e        resp_kind,
    output logic [PAGE_W-1:0] resp_page
);
    // Capture a decided answer or a finished walk for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_kind  <= RK_PAGE;
            resp_page  <= '0;
        end else begin
            resp_valid <= load_req | load_walk;
            if (load_walk) begin
                resp_kind <= RK_PAGE;
                resp_page <= walk_page;
            end else if (load_req) begin
                resp_kind <= req_kind;
                resp_page <= (req_kind == RK_PAGE) ? req_page : '0;
            end
        end
    end

    p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_req && load_walk));
endmodule

// File: rtl/fetch_miss_resp.sv
// Top: answers fetch translation requests that missed the first-level TLB.
// Assumes: the lookup result, speculative and idle flags arrive with req_valid.
module fetch_miss_resp
    import fmr_pkg::*;
#(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_abort_en,
    input  logic              req_valid,
    input  logic              req_spec,
    input  logic              pipe_idle,
    input  logic              l2_hit,
    input  logic [PAGE_W-1:0] l2_page,
    output logic              ready,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [PAGE_W-1:0] resp_page,
    output logic              walk_req,
    input  logic              walk_gnt,
    input  logic              walk_done,
    input  logic [PAGE_W-1:0] walk_page
);
    resp_kind_e kind_dec;
    resp_kind_e kind_q;
    logic       accept;
    logic       walk_start;
    logic       walk_fin;

    fmr_classify u_classify (
        .l2_hit   (l2_hit),
        .spec     (req_spec),
        .idle     (pipe_idle),
        .abort_en (spec_abort_en),
        .kind     (kind_dec)
    );

    // A request is taken only while no walk is outstanding.
    always_comb begin
        accept     = req_valid & ready;
        walk_start = accept & (kind_dec == RK_WALK);
    end

    fmr_walk_fsm u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_start),
        .walk_gnt  (walk_gnt),
        .walk_done (walk_done),
        .walk_req  (walk_req),
        .ready     (ready),
        .finish    (walk_fin)
    );

    fmr_resp_reg #(.PAGE_W(PAGE_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (accept),
        .req_kind   (kind_dec),
        .req_page   (l2_page),
        .load_walk  (walk_fin),
        .walk_page  (walk_page),
        .resp_valid (resp_valid),
        .resp_kind  (kind_q),
        .resp_page  (resp_page)
    );

    // Expose the response code as plain bits.
    always_comb resp_kind = kind_q;

    p_hit_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ready && l2_hit |=>
            resp_valid && resp_kind == 2'b00 && resp_page == $past(l2_page));
    p_abort_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_kind == 2'b01 |-> $past(spec_abort_en && req_spec));
    p_walk_raises_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_kind == 2'b11 |-> walk_req && !ready);
    p_resp_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && ready) || $past(walk_done));
    p_busy_no_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready && !walk_done |=> !resp_valid);
endmodule

// File: tb/fetch_miss_resp_bench.sv
module fetch_miss_resp_bench;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spec_abort_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_spec = 1'b0;
    logic          pipe_idle = 1'b0;
    logic          l2_hit = 1'b0;
    logic [PW-1:0] l2_page = '0;
    logic          ready;
    logic          resp_valid;
    logic [1:0]    resp_kind;
    logic [PW-1:0] resp_page;
    logic          walk_req;
    logic          walk_gnt = 1'b0;
    logic          walk_done = 1'b0;
    logic [PW-1:0] walk_page = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    fetch_miss_resp #(.PAGE_W(PW)) u_fetch_miss_resp (
        .clk(clk), .rst_n(rst_n), .spec_abort_en(spec_abort_en),
        .req_valid(req_valid), .req_spec(req_spec), .pipe_idle(pipe_idle),
        .l2_hit(l2_hit), .l2_page(l2_page), .ready(ready),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_page(resp_page),
        .walk_req(walk_req), .walk_gnt(walk_gnt), .walk_done(walk_done),
        .walk_page(walk_page)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_kind(input bit h, input bit s,
                                               input bit i, input bit e);
        if (h) return 2'b00;
        if (s && e) return 2'b01;
        if (i) return 2'b11;
        return 2'b10;
    endfunction

    // Runs a walk to completion; entered at a negedge with walk_req expected high.
    task automatic finish_walk(input logic [PW-1:0] pg);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(walk_req === 1'b1, "R8 hold", walk_req, 1);
            chk(ready === 1'b0, "R10 busy", ready, 0);
        end
        walk_gnt = 1'b1;
        @(negedge clk);
        walk_gnt = 1'b0;
        chk(walk_req === 1'b0, "R8 drop", walk_req, 0);
        // request during walk must be ignored
        req_valid = 1'b1; l2_hit = 1'b1; l2_page = 20'hBAD;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b0, "R7 busy ignored", resp_valid, 0);
        chk(ready === 1'b0, "R10 still busy", ready, 0);
        walk_done = 1'b1; walk_page = pg;
        @(negedge clk);
        walk_done = 1'b0;
        chk(resp_valid === 1'b1 && resp_kind === 2'b00, "R9 walked page kind",
            {resp_valid, resp_kind}, 3'b100);
        chk(resp_page === pg, "R9 walked page", resp_page, pg);
        chk(ready === 1'b1, "R10 ready back", ready, 1);
        @(negedge clk);
        chk(resp_valid === 1'b0, "R7 single pulse after walk", resp_valid, 0);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(resp_valid === 1'b0, "R6 resp low in reset", resp_valid, 0);
        chk(walk_req === 1'b0, "R6 walk_req low in reset", walk_req, 0);
        chk(ready === 1'b1, "R6 ready in reset", ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(resp_valid === 1'b0 && walk_req === 1'b0 && ready === 1'b1,
            "R6 after reset", {resp_valid, walk_req, ready}, 3'b001);

        for (int rep = 0; rep < 3; rep++) begin
            for (int v = 0; v < 16; v++) begin
                bit h, s, i, e;
                logic [1:0] ek;
                logic [PW-1:0] pg;
                h = v[0]; s = v[1]; i = v[2]; e = v[3];
                ek = expect_kind(h, s, i, e);
                pg = PW'(32'h1234 * (v + 1) + rep * 32'h777);
                req_valid = 1'b1; l2_hit = h; req_spec = s; pipe_idle = i;
                spec_abort_en = e; l2_page = pg;
                @(negedge clk);
                req_valid = 1'b0; l2_hit = 1'b0; req_spec = 1'b0;
                pipe_idle = 1'b0; l2_page = '0;
                chk(resp_valid === 1'b1, "R7 one pulse", resp_valid, 1);
                if (ek == 2'b00)
                    chk(resp_kind === ek && resp_page === pg, "R1 hit page",
                        {resp_kind, resp_page}, {ek, pg});
                else if (ek == 2'b01)
                    chk(resp_kind === ek, "R2 abort", resp_kind, ek);
                else if (ek == 2'b10)
                    chk(resp_kind === ek, s ? "R5 spec ignored retry" : "R3 retry",
                        resp_kind, ek);
                else
                    chk(resp_kind === ek && walk_req === 1'b1 && ready === 1'b0,
                        s ? "R5 spec ignored walk" : "R4 walk",
                        {resp_kind, walk_req, ready}, {ek, 2'b10});
                if (ek == 2'b11) begin
                    finish_walk(pg ^ 20'hF0F0F);
                end else begin
                    @(negedge clk);
                    chk(resp_valid === 1'b0, "R7 pulse ends", resp_valid, 0);
                    chk(ready === 1'b1 && walk_req === 1'b0, "R10 no walk",
                        {ready, walk_req}, 2'b10);
                end
            end
        end

        // Back-to-back requests: each gets its own response.
        spec_abort_en = 1'b1;
        req_valid = 1'b1; l2_hit = 1'b0; req_spec = 1'b1;
        @(negedge clk);
        chk(resp_valid === 1'b1 && resp_kind === 2'b01, "R2 back-to-back 1",
            {resp_valid, resp_kind}, 3'b101);
        req_spec = 1'b0; pipe_idle = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b1 && resp_kind === 2'b10, "R3 back-to-back 2",
            {resp_valid, resp_kind}, 3'b110);
        @(negedge clk);
        chk(resp_valid === 1'b0, "R7 idle no pulse", resp_valid, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule